// File: doc/BRIEF.md
# Debounced Differential Clock Stop Controller

This block produces a set of differential clock channels from one reference clock and can stop and restart them cleanly under an active-low stop request. The output clock runs at half the reference rate: each channel's true leg holds each level for exactly one reference cycle. The stop request may arrive with no timing relation to the clock. It is synchronized first. It is then accepted only once it reads the same value at two consecutive rising edges of the complement output clock.

Each channel has its own stoppable bit on a parallel control input. Only channels with that bit set respond to a stop. A global three-state bit selects where stopped channels park. With the bit clear, the true leg parks high and driven while the complement leg sits low and undriven. With the bit set, both legs park low and undriven. Once a deassertion is recognized, the controller waits a parameterized number of output periods, nominally two and at most six. It then releases every stopped channel on the same edge, so they all run in phase with the free-running ones. In three-state mode, the true legs are driven high again during that wait.

Top module: `dcs_clkstop_top`

## Requirements
- R1: A low level on `stop_ni` stops every channel whose `stoppable_i` bit is 1, with the output clock running at half the `clk_i` rate. A high level on `stop_ni` leaves all channels running.
- R2: A stop request is recognized only when the synchronized level reads the same at two consecutive complement-clock rising edges. A low pulse lasting two `clk_i` cycles or less leaves every output unchanged.
- R3: A channel whose stoppable bit is 0 always has both enables at 1, `clk_c_o` equal to the inverse of `clk_t_o`, and `clk_t_o` toggling every `clk_i` cycle.
- R4: A stoppable channel parks only on the edge where its true leg would rise, so the cycle before parking shows `clk_t_o` low. Its outputs then stay constant while the stop holds.
- R5: With `tristate_i` = 0, a parked channel shows `clk_t_o`=1 and `oe_t_o`=1, with `clk_c_o`=0 and `oe_c_o`=0.
- R6: With `tristate_i` = 1, a parked channel shows `clk_t_o`=0 and `clk_c_o`=0, with both enables at 0.
- R7: After a recognized deassertion, all parked channels resume on the same edge after WAKE_PERIODS complement periods. The resume edge takes the true leg from high to low. In `clk_i` cycles, it lies between 2*WAKE_PERIODS+2 and 2*WAKE_PERIODS+10 after `stop_ni` rises.
- R8: In three-state mode, every parked channel shows `clk_t_o`=1 with `oe_t_o`=1 for at least one cycle between recognition of the deassertion and the restart.
- R9: While reset is held, every channel is running and driven, with `clk_t_o`=0 and `clk_c_o`=1. After release, all channels toggle.
- R10: All channels with `oe_c_o`=1 share the same `clk_t_o` level in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the output clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_ni | input | 1 | Asynchronous active-low stop request |
| stoppable_i | input | NCH | Per-channel stoppable bits (1 = responds to stop) |
| tristate_i | input | 1 | Park mode: 0 = true high driven, 1 = both legs low undriven |
| clk_t_o | output | NCH | True leg level per channel |
| clk_c_o | output | NCH | Complement leg level per channel |
| oe_t_o | output | NCH | True leg drive enable per channel |
| oe_c_o | output | NCH | Complement leg drive enable per channel |

## Verification
The hardest situation to reach from the ports is the exact parking and resume instant of each channel, mixed with channels that run free. For every stoppable mask of a four-channel build, in both park modes, the bench issues a long stop. It records the cycle in which each channel's complement enable drops and the true level seen the cycle before. It then releases the stop and checks that the restart happens in a single cycle for the whole mask, at the falling true edge and inside the latency window. Short stop pulses are placed between these cases to show that the debounce rejects them.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_HALT = 2'd1,
    MODE_WAKE = 2'd2
  } dcs_mode_e;
endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dcs_debounce.sv
module dcs_debounce (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_en_i,
  input  logic req_n_i,
  output logic stop_o
);
  logic samp_q, samp_d;
  logic stop_q, stop_d;

  always_comb begin
    samp_d = samp_q;
    stop_d = stop_q;
    if (edge_en_i) begin
      samp_d = req_n_i;
      if (req_n_i == samp_q) stop_d = ~req_n_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b1;
      stop_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      stop_q <= stop_d;
    end
  end

  assign stop_o = stop_q;
endmodule

// File: rtl/dcs_wake_ctl.sv
module dcs_wake_ctl
  import dcs_pkg::*;
#(
  parameter int unsigned WAKE_PERIODS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_en_i,
  input  logic stop_i,
  output logic halt_o,
  output logic release_o
);
  localparam int unsigned CW = (WAKE_PERIODS > 1) ? $clog2(WAKE_PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAKE_PERIODS - 1);

  dcs_mode_e     mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    rel    = 1'b0;
    unique case (mode_q)
      MODE_RUN:  if (stop_i) mode_d = MODE_HALT;
      MODE_HALT: if (!stop_i) begin
                   mode_d = MODE_WAKE;
                   cnt_d  = '0;
                 end
      MODE_WAKE: if (stop_i) begin
                   mode_d = MODE_HALT;
                 end else if (edge_en_i) begin
                   if (cnt_q == LAST) begin
                     rel    = 1'b1;
                     mode_d = MODE_RUN;
                   end else begin
                     cnt_d = cnt_q + 1'b1;
                   end
                 end
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign halt_o    = (mode_q == MODE_HALT);
  assign release_o = rel;
endmodule

// File: rtl/dcs_lane.sv
module dcs_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_i,
  input  logic stoppable_i,
  input  logic halt_i,
  input  logic release_i,
  input  logic tristate_i,
  output logic t_o,
  output logic c_o,
  output logic oe_t_o,
  output logic oe_c_o
);
  logic run_q, run_d;
  logic rise_edge;

  assign rise_edge = ~ph_i;

  always_comb begin
    run_d = run_q;
    if (run_q && halt_i && stoppable_i && rise_edge) run_d = 1'b0;
    else if (!run_q && release_i)                    run_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b1;
    else         run_q <= run_d;
  end

  always_comb begin
    if (run_q) begin
      t_o = ph_i;   c_o = ~ph_i; oe_t_o = 1'b1; oe_c_o = 1'b1;
    end else if (halt_i && tristate_i) begin
      t_o = 1'b0;   c_o = 1'b0;  oe_t_o = 1'b0; oe_c_o = 1'b0;
    end else begin
      t_o = 1'b1;   c_o = 1'b0;  oe_t_o = 1'b1; oe_c_o = 1'b0;
    end
  end
endmodule

// File: rtl/dcs_clkstop_top.sv
module dcs_clkstop_top #(
  parameter int unsigned NCH          = 4,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned WAKE_PERIODS = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           stop_ni,
  input  logic [NCH-1:0] stoppable_i,
  input  logic           tristate_i,
  output logic [NCH-1:0] clk_t_o,
  output logic [NCH-1:0] clk_c_o,
  output logic [NCH-1:0] oe_t_o,
  output logic [NCH-1:0] oe_c_o
);
  logic rst_meta_q, rst_q;
  logic ph_q, ph_d;
  logic stop_sync_n;
  logic stop_db;
  logic halt, release_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign ph_d = ~ph_q;

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  dcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_q), .d_i(stop_ni), .q_o(stop_sync_n)
  );

  dcs_debounce u_deb (
    .clk_i(clk_i), .rst_ni(rst_q), .edge_en_i(ph_q),
    .req_n_i(stop_sync_n), .stop_o(stop_db)
  );

  dcs_wake_ctl #(.WAKE_PERIODS(WAKE_PERIODS)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_q), .edge_en_i(ph_q), .stop_i(stop_db),
    .halt_o(halt), .release_o(release_all)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    dcs_lane u_lane (
      .clk_i(clk_i), .rst_ni(rst_q), .ph_i(ph_q),
      .stoppable_i(stoppable_i[g]), .halt_i(halt), .release_i(release_all),
      .tristate_i(tristate_i),
      .t_o(clk_t_o[g]), .c_o(clk_c_o[g]), .oe_t_o(oe_t_o[g]), .oe_c_o(oe_c_o[g])
    );
  end
endmodule

// File: rtl/dcs_clkstop_chk.sv
module dcs_clkstop_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] t_i,
  input logic [NCH-1:0] c_i,
  input logic [NCH-1:0] oe_t_i,
  input logic [NCH-1:0] oe_c_i
);
  AST_IN_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((t_i & oe_c_i) == oe_c_i) || ((t_i & oe_c_i) == '0)); // R10

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_RUN_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_c_i[g] |-> (oe_t_i[g] && (c_i[g] == ~t_i[g]))); // R3
    AST_UNDRIVEN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_c_i[g] |-> !c_i[g]); // R5
    AST_TRI_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_t_i[g] |-> (!t_i[g] && !oe_c_i[g])); // R6
    AST_PARK_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(oe_c_i[g]) |-> !$past(t_i[g])); // R4
    AST_RESUME_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oe_c_i[g]) |-> (!t_i[g] && $past(t_i[g]))); // R7
    AST_WAKE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(oe_t_i[g]) |-> (t_i[g] && !oe_c_i[g])); // R8
  end
endmodule

bind dcs_clkstop_top dcs_clkstop_chk #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .t_i(clk_t_o), .c_i(clk_c_o),
  .oe_t_i(oe_t_o), .oe_c_i(oe_c_o)
);

// File: tb/dcs_clkstop_top_tb_top.sv
`timescale 1ns/1ps
module dcs_clkstop_top_tb_top;
  localparam int NCH  = 4;
  localparam int WAKE = 2;
  localparam logic [NCH-1:0] ALL = {NCH{1'b1}};

  logic           clk = 1'b0;
  logic           rst_n;
  logic           stop_n;
  logic [NCH-1:0] en;
  logic           tri_r;
  logic [NCH-1:0] t, c, oet, oec;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  dcs_clkstop_top #(.NCH(NCH), .SYNC_STAGES(2), .WAKE_PERIODS(WAKE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .stoppable_i(en),
    .tristate_i(tri_r), .clk_t_o(t), .clk_c_o(c), .oe_t_o(oet), .oe_c_o(oec)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_running(input logic [NCH-1:0] lanes, input string req);
    logic [NCH-1:0] pt;
    pt = t;
    @(negedge clk);
    chk((oet & lanes) == lanes, req, "oe_t running", int'(oet & lanes), int'(lanes));
    chk((oec & lanes) == lanes, req, "oe_c running", int'(oec & lanes), int'(lanes));
    chk(((c ^ t) & lanes) == lanes, req, "complement", int'(c ^ t), int'(lanes));
    chk(((t ^ pt) & lanes) == lanes, req, "toggle", int'(t ^ pt), int'(lanes));
  endtask

  task automatic run_case(input logic [NCH-1:0] mask, input logic tm);
    logic [NCH-1:0] prev_t, seen, snap_t, snap_oe, saw_high, exp_t, exp_oe;
    bit done, short_ok;
    int k;
    @(negedge clk);
    en = mask; tri_r = tm;
    repeat (6) @(negedge clk);
    check_running(ALL, "R1");
    // stop request
    stop_n = 1'b0;
    seen = '0;
    prev_t = t;
    for (int cyc = 0; cyc < 30; cyc++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (!seen[i] && !oec[i]) begin
          seen[i] = 1'b1;
          chk(!prev_t[i], "R4", "true level before park", int'(prev_t[i]), 0);
        end
      end
      prev_t = t;
    end
    chk(seen == mask, "R1", "parked set", int'(seen), int'(mask));
    exp_t  = tm ? '0 : mask;
    exp_oe = tm ? '0 : mask;
    chk((t & mask) == exp_t, tm ? "R6" : "R5", "parked true", int'(t & mask), int'(exp_t));
    chk((oet & mask) == exp_oe, tm ? "R6" : "R5", "parked oe_t", int'(oet & mask), int'(exp_oe));
    chk((c & mask) == '0, tm ? "R6" : "R5", "parked comp", int'(c & mask), 0);
    chk((oec & mask) == '0, tm ? "R6" : "R5", "parked oe_c", int'(oec & mask), 0);
    check_running(~mask, "R3");
    snap_t = t & mask; snap_oe = oet & mask;
    repeat (4) @(negedge clk);
    chk(((t & mask) == snap_t) && ((oet & mask) == snap_oe), "R4", "parked stable",
        int'(t & mask), int'(snap_t));
    // release
    stop_n = 1'b1;
    k = 0; done = 1'b0; saw_high = '0; prev_t = t;
    if (mask != '0) begin
      for (int cyc = 0; cyc < 40 && !done; cyc++) begin
        @(negedge clk);
        k++;
        if ((oec & mask) != '0) begin
          done = 1'b1;
          chk((oec & mask) == mask, "R7", "same-edge resume", int'(oec & mask), int'(mask));
          chk((t & mask) == '0, "R7", "resume true low", int'(t & mask), 0);
          chk((prev_t & mask) == mask, "R7", "true high before resume", int'(prev_t & mask), int'(mask));
          chk(k >= 2*WAKE+2 && k <= 2*WAKE+10, "R7", "resume latency", k, 2*WAKE+4);
          if (tm) chk(saw_high == mask, "R8", "true driven high in wake", int'(saw_high), int'(mask));
        end else begin
          for (int i = 0; i < NCH; i++)
            if (mask[i] && oet[i] && t[i]) saw_high[i] = 1'b1;
        end
        prev_t = t;
      end
      chk(done, "R7", "resume seen", int'(done), 1);
    end else begin
      repeat (20) @(negedge clk);
    end
    repeat (2) begin
      @(negedge clk);
      chk((t == '0) || (t == ALL), "R10", "in phase", int'(t), 0);
    end
    check_running(ALL, "R7");
    // short pulse, rejected by debounce
    stop_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    stop_n = 1'b1;
    short_ok = 1'b1;
    for (int cyc = 0; cyc < 20; cyc++) begin
      @(negedge clk);
      if (oec != ALL || oet != ALL || (c ^ t) != ALL) short_ok = 1'b0;
    end
    chk(short_ok, "R2", "short pulse ignored", int'(oec), int'(ALL));
  endtask

  initial begin
    rst_n = 1'b0; stop_n = 1'b1; en = ALL; tri_r = 1'b0;
    repeat (4) @(negedge clk);
    chk(t == '0 && c == ALL, "R9", "reset levels", int'({t, c}), int'({{NCH{1'b0}}, ALL}));
    chk(oet == ALL && oec == ALL, "R9", "reset enables", int'({oet, oec}), int'({ALL, ALL}));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_running(ALL, "R9");
    for (int m = 0; m < (1 << NCH); m++) begin
      run_case(NCH'(m), 1'b0);
      run_case(NCH'(m), 1'b1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule